// File: doc/BRIEF.md
# IrDA SIR Infrared Pulse Encoder

This block sits between the serial transmit line of a host UART and an infrared optical transceiver. It watches the UART line, and when the line falls at a start bit it opens a frame of ten bit cells. A cell is sixteen ticks of a bit-rate clock enable that runs at sixteen times the baud rate. For every cell whose bit is zero it emits one short high pulse on the infrared output. A cell whose bit is one leaves the output low.

The UART line is first passed through a synchronizer that samples on ticks. The falling edge seen at its output anchors the whole frame. After that, every cell boundary follows the previous one by exactly sixteen ticks, so jitter in finding the edge moves the frame as a whole and never stretches a bit. Each pulse lies inside its cell, after a fixed stretch of low ticks. An enable input stops the encoder and forces the output low. When enable returns high, a guard period measured in system clocks must pass before a new frame can start.

Top module: `irda_sir_encoder`

## Requirements
- R1: After a synchronous reset, `ir_tx_o` is low and stays low until a frame has been started by a falling edge of the UART line.
- R2: In a frame, a cell whose synchronized UART value is 0 when sampled at tick position 7 of that cell drives `ir_tx_o` high after the tick edges at positions 7, 8 and 9. The output is high for exactly 3 ticks and low at all other positions of the cell.
- R3: A cell whose sampled UART value is 1 keeps `ir_tx_o` low for all 16 tick positions.
- R4: The UART line passes through a 2-stage synchronizer clocked on ticks. If `uart_tx_i` is first sampled low at tick k (with `ir_en_i` high and the guard expired), then that tick-edge index k+2 is position 0 of the start cell. The first pulse therefore appears after tick edge k+9.
- R5: A frame is exactly 10 cells of 16 ticks each: start, 8 data bits least-significant first, and stop. Line transitions inside a frame do not restart it. The encoder is idle again after 160 ticks, so a next start bit that follows the stop bit with no gap is detected.
- R6: While `ir_en_i` is low, `ir_tx_o` is low from the next clock edge on, and any frame in progress is abandoned.
- R7: A falling edge of the UART line is ignored until `ir_en_i` has been high for WAKE_CYCLES (default 1000) consecutive clocks. The guard also runs after reset.
- R8: While `ir_en_i` is high, `ir_tx_o` changes only at clock edges where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Bit-clock enable, 16 pulses per bit time |
| uart_tx_i | input | 1 | Transmit line from the host UART, idle high |
| ir_en_i | input | 1 | Encoder enable, active high |
| ir_tx_o | output | 1 | Pulse output to the infrared transceiver |

## Verification
The hardest situation to reach is a falling edge that arrives while the wake guard is still counting after enable returns. To make it worse, that edge comes right after a frame was cut short by a disable. The stimulus builds exactly this timeline. It starts an all-zero frame, drops enable inside its third cell, raises enable again, and sends a complete frame well inside the guard window. The bench then expects silence, and after the guard expires it expects a properly placed frame. Back-to-back frames with no idle tick test the re-arming just after the stop cell.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_RUN  = 1'b1
  } frame_st_t;

  function automatic int unsigned frame_cells(input int unsigned data_bits,
                                              input int unsigned stop_bits);
    return 1 + data_bits + stop_bits;
  endfunction

endpackage

// File: rtl/irsir_tx_sync.sv
module irsir_tx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic line_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES:0] chain_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst)         chain_q[g] <= 1'b1;
        else if (tick_i) chain_q[g] <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst)         chain_q[g] <= 1'b1;
        else if (tick_i) chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/irsir_wake_guard.sv
module irsir_wake_guard #(
  parameter int unsigned WAKE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic ready_o
);

  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i)      cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = (cnt_q == LIMIT);

  a_r7_guard_never_past_limit: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

endmodule

// File: rtl/irsir_frame_ctl.sv
module irsir_frame_ctl
  import irsir_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned DATA_BITS     = 8,
  parameter int unsigned STOP_BITS     = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic ready_i,
  input  logic fall_i,
  output logic in_frame_o,
  output logic [$clog2(TICKS_PER_BIT)-1:0] pos_o
);

  localparam int unsigned PW    = $clog2(TICKS_PER_BIT);
  localparam int unsigned CELLS = frame_cells(DATA_BITS, STOP_BITS);
  localparam int unsigned CLW   = $clog2(CELLS);
  localparam logic [PW-1:0]  POS_LAST  = PW'(TICKS_PER_BIT - 1);
  localparam logic [CLW-1:0] CELL_LAST = CLW'(CELLS - 1);

  frame_st_t      st_q;
  logic [PW-1:0]  pos_q;
  logic [CLW-1:0] cell_q;

  always_ff @(posedge clk) begin
    if (rst || !ready_i) begin
      st_q   <= FR_IDLE;
      pos_q  <= '0;
      cell_q <= '0;
    end else if (tick_i) begin
      unique case (st_q)
        FR_IDLE: begin
          if (fall_i) begin
            st_q   <= FR_RUN;
            pos_q  <= PW'(1);
            cell_q <= '0;
          end
        end
        FR_RUN: begin
          if (pos_q == POS_LAST) begin
            pos_q <= '0;
            if (cell_q == CELL_LAST) begin
              st_q   <= FR_IDLE;
              cell_q <= '0;
            end else begin
              cell_q <= cell_q + 1'b1;
            end
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  assign in_frame_o = (st_q == FR_RUN);
  assign pos_o      = pos_q;

  a_r7_idle_while_guarded: assert property (@(posedge clk) disable iff (rst)
    !ready_i |=> (st_q == FR_IDLE));

  a_r5_cell_in_range: assert property (@(posedge clk) disable iff (rst)
    (st_q == FR_RUN) |-> (cell_q <= CELL_LAST));

  a_r5_no_restart_in_frame: assert property (@(posedge clk) disable iff (rst)
    (st_q == FR_RUN && ready_i && tick_i && pos_q != POS_LAST) |=>
      (st_q == FR_RUN && pos_q == $past(pos_q) + 1'b1));

endmodule

// File: rtl/irsir_pulse_shaper.sv
module irsir_pulse_shaper #(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned PULSE_START   = 7,
  parameter int unsigned PULSE_LEN     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic en_i,
  input  logic in_frame_i,
  input  logic [$clog2(TICKS_PER_BIT)-1:0] pos_i,
  input  logic line_i,
  output logic ir_o
);

  localparam int unsigned PW = $clog2(TICKS_PER_BIT);
  localparam logic [PW-1:0] P_FIRST = PW'(PULSE_START);
  localparam logic [PW-1:0] P_LAST  = PW'(PULSE_START + PULSE_LEN - 1);
  localparam int unsigned   RW = $clog2(PULSE_LEN + 2);

  logic ir_q;
  logic zero_q;
  logic [RW-1:0] hi_run_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      ir_q   <= 1'b0;
      zero_q <= 1'b0;
    end else if (tick_i) begin
      if (in_frame_i && pos_i == P_FIRST) begin
        zero_q <= ~line_i;
        ir_q   <= ~line_i;
      end else if (in_frame_i && pos_i > P_FIRST && pos_i <= P_LAST) begin
        ir_q <= zero_q;
      end else begin
        ir_q <= 1'b0;
      end
    end
  end

  assign ir_o = ir_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i)  hi_run_q <= '0;
    else if (tick_i)   hi_run_q <= ir_q ? ((hi_run_q == RW'(PULSE_LEN + 1)) ? hi_run_q : hi_run_q + 1'b1) : '0;
  end

  a_r2_pulse_not_too_wide: assert property (@(posedge clk) disable iff (rst)
    hi_run_q <= RW'(PULSE_LEN));

  a_r6_low_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !ir_q);

  a_r8_only_on_ticks: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && en_i) |=> $stable(ir_q));

endmodule

// File: rtl/irda_sir_encoder.sv
module irda_sir_encoder #(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned PULSE_START   = 7,
  parameter int unsigned PULSE_LEN     = 3,
  parameter int unsigned DATA_BITS     = 8,
  parameter int unsigned STOP_BITS     = 1,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned WAKE_CYCLES   = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic uart_tx_i,
  input  logic ir_en_i,
  output logic ir_tx_o
);

  localparam int unsigned PW = $clog2(TICKS_PER_BIT);

  logic          line_s;
  logic          fall_s;
  logic          ready_s;
  logic          in_frame_s;
  logic [PW-1:0] pos_s;

  irsir_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .line_i (uart_tx_i),
    .line_o (line_s),
    .fall_o (fall_s)
  );

  irsir_wake_guard #(.WAKE_CYCLES(WAKE_CYCLES)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .en_i    (ir_en_i),
    .ready_o (ready_s)
  );

  irsir_frame_ctl #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .DATA_BITS     (DATA_BITS),
    .STOP_BITS     (STOP_BITS)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .ready_i    (ready_s),
    .fall_i     (fall_s),
    .in_frame_o (in_frame_s),
    .pos_o      (pos_s)
  );

  irsir_pulse_shaper #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .PULSE_START   (PULSE_START),
    .PULSE_LEN     (PULSE_LEN)
  ) u_shape (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .en_i       (ir_en_i),
    .in_frame_i (in_frame_s),
    .pos_i      (pos_s),
    .line_i     (line_s),
    .ir_o       (ir_tx_o)
  );

  a_r6_disable_forces_idle_output: assert property (@(posedge clk) disable iff (rst)
    (!ir_en_i && $past(!ir_en_i)) |-> !ir_tx_o);

endmodule

// File: tb/tb_irda_sir_encoder.sv
module tb_irda_sir_encoder;

  localparam int NSTEP = 3400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic utx = 1'b1;
  logic en = 1'b1;
  logic irtx;

  always #5 clk = ~clk;

  irda_sir_encoder dut (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .uart_tx_i (utx),
    .ir_en_i   (en),
    .ir_tx_o   (irtx)
  );

  logic txv [NSTEP];
  logic env [NSTEP];
  logic expv [NSTEP];
  logic obs [NSTEP];
  byte  tagc [NSTEP];

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic string tag_name(input byte c);
    case (c)
      2: return "R2";
      3: return "R3";
      6: return "R6";
      7: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: ir_tx_o=%0b expected %0b at %0t", req, act, exp_v, $time);
    end
  endtask

  // lay a frame on the line whose first low sample is step k; mark
  // pulses for the first ncells cells when expected to run
  task automatic put_frame(input int k, input byte b, input int ncells, input byte rtag);
    for (int c = 0; c < 10; c++) begin
      logic bit_v;
      bit_v = (c == 0) ? 1'b0 : (c == 9) ? 1'b1 : b[c-1];
      for (int p = 0; p < 16; p++) txv[k + 16*c + p] = bit_v;
      if (c < ncells) begin
        for (int p = 0; p < 16; p++)
          if (tagc[k + 2 + 16*c + p] == 0) tagc[k + 2 + 16*c + p] = 3;
        if (!bit_v)
          for (int p = 7; p < 10; p++) begin
            expv[k + 2 + 16*c + p] = 1'b1;
            tagc[k + 2 + 16*c + p] = 2;
          end
      end else begin
        for (int p = 0; p < 16; p++)
          if (tagc[k + 2 + 16*c + p] == 0) tagc[k + 2 + 16*c + p] = rtag;
      end
    end
  endtask

  initial begin
    int k;
    int rise_a;
    void'($urandom(32'h1dA5));
    for (int i = 0; i < NSTEP; i++) begin
      txv[i] = 1'b1; env[i] = 1'b1; expv[i] = 1'b0; obs[i] = 1'b0; tagc[i] = 0;
    end
    // R7: edge soon after reset lies inside the guard
    for (int i = 100; i < 120; i++) begin txv[i] = 1'b0; tagc[i+2] = 7; end
    for (int i = 122; i < 160; i++) tagc[i] = 7;
    // directed frames, back to back
    put_frame(400, 8'h00, 10, 3);
    put_frame(560, 8'hFF, 10, 3);
    put_frame(720, 8'h55, 10, 3);
    // random frames with small gaps
    k = 880;
    for (int f = 0; f < 10; f++) begin
      put_frame(k, byte'($urandom_range(0, 255)), 10, 3);
      k = k + 160 + int'($urandom_range(0, 5));
    end
    // abort: disable during cell 2 of an all-zero frame
    put_frame(2600, 8'h00, 2, 6);
    for (int i = 2640; i < 2650; i++) begin env[i] = 1'b0; tagc[i] = 6; end
    // frame inside the guard window is ignored
    put_frame(2800, 8'h00, 0, 7);
    // frame after the guard runs normally
    put_frame(3100, byte'($urandom_range(0, 255)), 10, 3);

    repeat (4) @(negedge clk);
    check("R1", irtx, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", irtx, 1'b0);

    for (int s = 0; s < NSTEP; s++) begin
      utx = txv[s];
      en = env[s];
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      obs[s] = irtx;
      check(tag_name(tagc[s]), irtx, expv[s]);
      @(negedge clk);
      check(env[s] ? "R8" : "R6", irtx, expv[s]);
      @(negedge clk);
      check(env[s] ? "R8" : "R6", irtx, expv[s]);
    end

    // R4: first rise of frame A lands nine ticks after its first low sample
    rise_a = -1;
    for (int s = 401; s < 560; s++)
      if (rise_a < 0 && obs[s] && !obs[s-1]) rise_a = s;
    n_run++;
    if (rise_a != 409) begin
      n_fail++;
      $display("FAIL R4: first pulse at step %0d expected %0d", rise_a, 409);
    end
    // R5: back-to-back 0xFF frame gives only its start pulse at 569
    check("R5", obs[569], 1'b1);
    check("R5", obs[585], 1'b0);
    // R5: all-zero frame, last data pulse sits 8 cells after the start pulse
    check("R5", obs[409 + 16*8], 1'b1);
    check("R5", obs[409 + 16*9], 1'b0);
    // R7: no pulse during the guarded frame
    check("R7", obs[2809], 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule